// File: doc/BRIEF.md
# Bank-Aware DRAM Request Picker

This block keeps a small pool of pending memory requests aimed at several DRAM banks and decides, every cycle, which one goes out next. Each request names a bank, a row, a column and whether it is a read or a write. The block remembers, per bank, which row was last opened by an issued request, so it can tell whether a waiting request is a column-only access or one that forces a row change.

Two picking rules are selectable by a mode pin. In plain first-come mode the oldest allowed request wins. In hit-first mode, any allowed request whose row matches its bank's open row wins over older requests that would change the row, and the oldest such hit is taken. Requests to banks marked busy by the command stage are passed over, and the next-oldest candidate is taken instead. Writes stay parked while any read is queued, unless the number of queued writes reaches a high mark. Once that happens, writes are drained ahead of reads.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the pool is empty, `iss_valid` is 0, `enq_ready` is 1, and no bank has an open row.
- R2: `enq_ready` is 1 exactly when fewer than DEPTH requests are held. A request is accepted on a clock edge where `enq_valid` and `enq_ready` are both 1.
- R3: With `frfcfs_en`=0, the presented request is the oldest eligible one.
- R4: With `frfcfs_en`=1, the oldest eligible request whose row equals its bank's open row is presented ahead of any older non-hit.
- R5: `iss_hit` is 1 exactly when the presented row equals the open row of its bank. When no eligible hit exists, the oldest eligible request is presented. On every accepted issue, the issued row becomes that bank's open row.
- R6: A request is eligible only while `bank_busy[bank]` is 0. Passed-over requests keep their age, and the next-oldest candidate is taken.
- R7: While fewer than WR_HI writes are held, a write (`enq_wr`=1) is ineligible whenever any read is held.
- R8: While WR_HI or more writes are held, reads are ineligible and writes are eligible.
- R9: An issue is accepted when `iss_valid` and `iss_ready` are both 1. That request leaves the pool, and the age order of the others is kept. While `iss_ready` is 0, nothing is removed.
- R10: An enqueue and an issue may be accepted in the same cycle. The new request becomes the youngest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Pool has room |
| enq_bank | input | BW | Bank of new request |
| enq_row | input | ROW_W | Row of new request |
| enq_col | input | COL_W | Column of new request |
| enq_wr | input | 1 | 1 = write, 0 = read |
| bank_busy | input | NBANK | Per-bank in-progress flag |
| frfcfs_en | input | 1 | 1 = hit-first, 0 = oldest-first |
| iss_valid | output | 1 | A request is presented |
| iss_ready | input | 1 | Command stage takes the presented request |
| iss_bank | output | BW | Bank of presented request |
| iss_row | output | ROW_W | Row of presented request |
| iss_col | output | COL_W | Column of presented request |
| iss_wr | output | 1 | Presented request is a write |
| iss_hit | output | 1 | Presented request hits its bank's open row |

## Verification
Enqueue and issue can be accepted on the same edge. Removing an entry from the middle of the pool then shifts the younger entries while the new request lands behind them. The bench causes this by driving `enq_valid` and `iss_ready` together over long random stretches with a full pool and a nearly empty one. It judges the result by comparing every presented request, hit flag and ready against a behavioural queue model on every cycle. A second overlap is an issue that changes a bank's open row in the same cycle that an older request to that bank turns into a hit. This shows up as `iss_hit` and the picked entry on the next cycle.

// File: rtl/frfcfs_sched.sv
module frfcfs_sched #(
  parameter int DEPTH = 8,
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int WR_HI = 6,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [BW-1:0]    enq_bank,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [COL_W-1:0] enq_col,
  input  logic             enq_wr,
  input  logic [NBANK-1:0] bank_busy,
  input  logic             frfcfs_en,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [BW-1:0]    iss_bank,
  output logic [ROW_W-1:0] iss_row,
  output logic [COL_W-1:0] iss_col,
  output logic             iss_wr,
  output logic             iss_hit
);

  typedef struct packed {
    logic             wr;
    logic [BW-1:0]    bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } ent_t;

  ent_t             q     [DEPTH];
  logic             q_vld [DEPTH];
  logic [NBANK-1:0] open_vld;
  logic [ROW_W-1:0] open_row [NBANK];

  logic [CW-1:0]    cnt, nwr;
  logic             any_rd, drain, f_any, f_hit;
  logic [DEPTH-1:0] hit, elig;
  logic [IW-1:0]    sel_any, sel_hit, sel;

  always_comb begin
    cnt = '0; nwr = '0; any_rd = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (q_vld[i]) begin
        cnt = cnt + 1'b1;
        if (q[i].wr) nwr = nwr + 1'b1;
        else any_rd = 1'b1;
      end
    drain = (nwr >= CW'(WR_HI));
    for (int i = 0; i < DEPTH; i++) begin
      hit[i]  = open_vld[q[i].bank] && (open_row[q[i].bank] == q[i].row);
      elig[i] = q_vld[i] && !bank_busy[q[i].bank] &&
                (drain ? q[i].wr : (!q[i].wr || !any_rd));
    end
    f_any = 1'b0; f_hit = 1'b0; sel_any = '0; sel_hit = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin f_any = 1'b1; sel_any = IW'(i); end
      if (elig[i] && hit[i]) begin f_hit = 1'b1; sel_hit = IW'(i); end
    end
  end

  assign sel       = (frfcfs_en && f_hit) ? sel_hit : sel_any;
  assign iss_valid = f_any;
  assign iss_bank  = q[sel].bank;
  assign iss_row   = q[sel].row;
  assign iss_col   = q[sel].col;
  assign iss_wr    = q[sel].wr;
  assign iss_hit   = hit[sel];
  assign enq_ready = (cnt < CW'(DEPTH));

  wire           pop  = iss_valid && iss_ready;
  wire           push = enq_valid && enq_ready;
  wire [CW-1:0]  wpos = cnt - CW'(pop);
  wire ent_t     new_e = '{wr: enq_wr, bank: enq_bank, row: enq_row, col: enq_col};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ent_t nxt_e;
    logic nxt_v;
    if (g < DEPTH - 1) begin : g_mid
      assign nxt_e = (pop && IW'(g) >= sel) ? q[g+1]     : q[g];
      assign nxt_v = (pop && IW'(g) >= sel) ? q_vld[g+1] : q_vld[g];
    end else begin : g_end
      assign nxt_e = q[g];
      assign nxt_v = (pop && IW'(g) >= sel) ? 1'b0 : q_vld[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_vld[g] <= 1'b0;
        q[g]     <= '0;
      end else if (push && wpos == CW'(g)) begin
        q_vld[g] <= 1'b1;
        q[g]     <= new_e;
      end else begin
        q_vld[g] <= nxt_v;
        q[g]     <= nxt_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= '0;
      for (int b = 0; b < NBANK; b++) open_row[b] <= '0;
    end else if (pop) begin
      open_vld[iss_bank] <= 1'b1;
      open_row[iss_bank] <= iss_row;
    end
  end

endmodule

module frfcfs_sched_chk #(
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic [NBANK-1:0] bank_busy,
  input logic             frfcfs_en,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [BW-1:0]    iss_bank,
  input logic [ROW_W-1:0] iss_row,
  input logic             iss_hit
);

  assert_busy_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !bank_busy[iss_bank]);

  assert_open_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_ready) && iss_valid && iss_bank == $past(iss_bank))
      |-> (iss_hit == (iss_row == $past(iss_row))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !(enq_valid && enq_ready)) ##1
      ($stable(bank_busy) && $stable(frfcfs_en))
      |-> (iss_valid && $stable(iss_bank) && $stable(iss_row)));

  assert_full_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && bank_busy == '0) |-> iss_valid);

endmodule

bind frfcfs_sched frfcfs_sched_chk #(.NBANK(NBANK), .ROW_W(ROW_W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .bank_busy(bank_busy), .frfcfs_en(frfcfs_en), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_bank(iss_bank), .iss_row(iss_row), .iss_hit(iss_hit));

// File: tb/frfcfs_sched_tb.sv
module frfcfs_sched_tb;
  localparam int DEPTH = 8, NBANK = 4, ROW_W = 8, COL_W = 6, WR_HI = 6, BW = 2;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, enq_wr = 0, frfcfs_en = 0, iss_ready = 0;
  logic [BW-1:0] enq_bank = 0;
  logic [ROW_W-1:0] enq_row = 0;
  logic [COL_W-1:0] enq_col = 0;
  logic [NBANK-1:0] bank_busy = 0;
  logic enq_ready, iss_valid, iss_wr, iss_hit;
  logic [BW-1:0] iss_bank;
  logic [ROW_W-1:0] iss_row;
  logic [COL_W-1:0] iss_col;

  always #5 clk = ~clk;

  frfcfs_sched u_dut (.*);

  typedef struct { int bank; int row; int col; int wr; } req_t;
  req_t mq[$];
  int open_r[NBANK];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit ev, input int b, input int r, input int c, input bit w,
                      input int busy, input bit mode, input bit rdy, input string tag);
    int nw, sa, sh, sel, eb;
    bit anyrd, drain, el, ht, ev_ok, ex_v;
    @(negedge clk);
    enq_valid = ev; enq_bank = b[BW-1:0]; enq_row = r[ROW_W-1:0]; enq_col = c[COL_W-1:0];
    enq_wr = w; bank_busy = busy[NBANK-1:0]; frfcfs_en = mode; iss_ready = rdy;
    #1;
    nw = 0; anyrd = 0;
    foreach (mq[i]) if (mq[i].wr) nw++; else anyrd = 1;
    drain = nw >= WR_HI;
    sa = -1; sh = -1;
    foreach (mq[i]) begin
      el = !busy[mq[i].bank] && (drain ? mq[i].wr : (!mq[i].wr || !anyrd));
      ht = open_r[mq[i].bank] == mq[i].row;
      if (el && sa < 0) sa = i;
      if (el && ht && sh < 0) sh = i;
    end
    sel = (mode && sh >= 0) ? sh : sa;
    ex_v = sa >= 0;
    ev_ok = mq.size() < DEPTH;
    chk("R2 enq_ready", enq_ready, ev_ok);
    chk({tag, " iss_valid"}, iss_valid, ex_v);
    if (ex_v) begin
      chk({tag, " bank"}, iss_bank, mq[sel].bank);
      chk({tag, " row"}, iss_row, mq[sel].row);
      chk({tag, " col"}, iss_col, mq[sel].col);
      chk({tag, " wr"}, iss_wr, mq[sel].wr);
      chk("R5 iss_hit", iss_hit, open_r[mq[sel].bank] == mq[sel].row);
    end
    @(posedge clk);
    if (ex_v && rdy) begin
      eb = mq[sel].bank;
      open_r[eb] = mq[sel].row;
      mq.delete(sel);
    end
    if (ev && ev_ok) mq.push_back('{b, r, c, w});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    foreach (open_r[k]) open_r[k] = -1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 enq_ready", enq_ready, 1);
    @(negedge clk); rst_n = 1;
    // R2: fill past capacity with no issue
    for (int i = 0; i < DEPTH + 2; i++) step(1, i % 4, i % 3, i, 0, 0, 0, 0, "R2");
    // R3: oldest-first drain
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 0, 0, 1, "R3");
    // R4, R5: open row 5 in bank 1, then older miss vs younger hit
    step(1, 1, 5, 1, 0, 0, 1, 1, "R5");
    step(1, 1, 9, 2, 0, 0, 1, 0, "R4");
    step(1, 1, 5, 3, 0, 0, 1, 0, "R4");
    step(1, 1, 5, 4, 0, 0, 1, 1, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R5");
    // R6: busy bank skipped, age kept
    step(1, 2, 1, 1, 0, 4, 0, 0, "R6");
    step(1, 3, 1, 2, 0, 4, 0, 1, "R6");
    step(0, 0, 0, 0, 0, 4, 0, 1, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6");
    // R7: write held behind read
    step(1, 0, 2, 1, 1, 0, 0, 0, "R7");
    step(1, 0, 3, 2, 0, 1, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R8: write count reaches high mark, writes drain ahead of reads
    step(1, 1, 1, 1, 0, 0, 1, 0, "R8");
    for (int i = 0; i < WR_HI; i++) step(1, i % 4, 7, i, 1, 0, 1, 0, "R8");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    // R9, R10: random overlapping enqueue and issue
    for (int i = 0; i < 6000; i++)
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 3, $urandom % 64, ($urandom % 3) == 0,
           (($urandom % 3) == 0) ? ($urandom % 16) : 0, (i / 500) % 2, ($urandom % 3) != 0,
           "R10");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule